// File: doc/BRIEF.md
# Dual-Channel Buffered Output Compare

This block turns the count of a shared free-running timer into two output waveforms. Each channel holds a compare value. When the timer count equals that value, the channel raises a match flag, can request an interrupt, and updates its output level. The timer itself sits outside the block. It supplies the count, its counting direction, a one-cycle pulse when the count is zero and a one-cycle pulse when the count reaches its top (compare-clear) value, and it also supplies that top value.

Software writes each compare value through a port. With a channel's buffer off, the write lands in the live compare register on the next edge. With the buffer on, the write is parked in a hidden holding register and copied to the live register at a selectable timer event, so a new value never takes effect in the middle of a period. Each channel can toggle on a match or set its level from the counting direction. A full-duty option gives clean 0% and 100% duty. A paired mode lets channel 1 toggle on a match with either compare value, which yields single-pin PWM whose duty is set by channel 0's value. An external stop input can freeze a channel whose pin-enable field requests it.

Top module: `cmp_out_pair`

## Requirements
- R1: On a clock edge with `rst_n` low, both compare values, both outputs, both match flags and both interrupt lines go to 0.
- R2: With `buf_en[n]` = 0, a cycle with `buf_wr[n]` = 1 places `buf_wdata` in the channel's compare value (`cmp_val0` or `cmp_val1`) on the next edge.
- R3: With `buf_en[n]` = 1, a write goes to a hidden holding register. The compare value changes only at a transfer event, when it takes the holding register's value as it stood before that edge. The event is `tmr_zero` when `xfer_top[n]` = 0 and `tmr_top` when `xfer_top[n]` = 1.
- R4: A channel is active when `ch_run[n]` = 1, the channel is not halted, and no stop request is present in that cycle. When an active channel sees `tmr_cnt` equal to its compare value and `lvl_mode[n]` = 0, its output inverts on the next edge.
- R5: With `lvl_mode[n]` = 1, a match drives the output to 1 when `tmr_dn` = 0 (counting up) and to 0 when `tmr_dn` = 1 (counting down).
- R6: While `ch_run[n]` = 0, the output takes `init_lvl[n]` on each edge, and no match takes effect.
- R7: A match on an active channel sets `match_flag[n]`. `flag_clr[n]` clears the flag, and a set in the same cycle wins. `irq[n]` is `match_flag[n]` AND `irq_en[n]`.
- R8: With `pair_pwm` = 1, channel 1 inverts its output when `tmr_cnt` equals either compare value. It inverts once when both are equal, and it ignores `lvl_mode[1]`. `match_flag[1]` still follows channel 1's own compare value only.
- R9: With `full_duty[n]` = 1 and `pair_pwm` = 0, a compare value of 0 drives the active output to `inv_lvl[n]` on each edge.
- R10: With `full_duty[n]` = 1, `pair_pwm` = 0 and a compare value of at least `tmr_top_val`, the output changes only in a `tmr_top` cycle. It goes to the inverse of `inv_lvl[n]` if no match occurred since the previous `tmr_top` cycle (the current cycle included), and otherwise holds. Values strictly between 0 and `tmr_top_val` follow R4 and R5.
- R11: For channel n, the pin-enable field is `pin_en0` for channel 0 and `pin_en1` for channel 1. If that field is 2'b11 and `ext_stop` = 1, the channel halts. While halted, the output holds its level and sets no flag. The halt is released only by `ch_run[n]` = 0.
- R12: `pin_drv[n]` is 1 exactly when that pin-enable field is not 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_cnt | input | W | Timer count |
| tmr_top_val | input | W | Timer top (compare-clear) value |
| tmr_dn | input | 1 | 1 while the timer counts down |
| tmr_zero | input | 1 | Pulse: timer count is zero |
| tmr_top | input | 1 | Pulse: timer reached its top |
| buf_wr | input | 2 | Per-channel compare write strobe |
| buf_wdata | input | W | Compare write data |
| ch_run | input | 2 | Per-channel run |
| buf_en | input | 2 | Per-channel buffer enable |
| xfer_top | input | 2 | Transfer at top (1) or at zero (0) |
| lvl_mode | input | 2 | Match sets level from direction (1) or toggles (0) |
| full_duty | input | 2 | Full-duty-range enable |
| inv_lvl | input | 2 | Full-duty rest level |
| init_lvl | input | 2 | Output level while not running |
| irq_en | input | 2 | Interrupt enable |
| flag_clr | input | 2 | Match flag clear strobe |
| pin_en0 | input | 2 | Channel 0 pin enable field |
| pin_en1 | input | 2 | Channel 1 pin enable field |
| pair_pwm | input | 1 | Channel 1 toggles on either compare value |
| ext_stop | input | 1 | External stop request |
| cmp_val0 | output | W | Live compare value, channel 0 |
| cmp_val1 | output | W | Live compare value, channel 1 |
| pin_out | output | 2 | Output levels |
| pin_drv | output | 2 | Pin drive valid |
| match_flag | output | 2 | Match flags |
| irq | output | 2 | Interrupt requests |

## Verification
The bench builds the block with an 8-bit count and drives a timer whose top is 9. A 10-step up-count period and an 18-step up/down period then fit in a few dozen cycles. Many buffer transfers, full-duty top events and paired-mode double matches therefore occur within a short run. Compare values of 0, exactly the top and above the top all fall inside the 8-bit range, so every full-duty region can be reached.

// File: rtl/cmp_pkg.sv
// Shared types for the dual output-compare block.
// Assumes: two channels, channel 1 is the one that can pair with channel 0.
package cmp_pkg;
    localparam int NUM_CH = 2;

    // Pin-enable field code that arms the external stop
    localparam logic [1:0] PIN_EN_STOPPABLE = 2'b11;

    typedef struct packed {
        logic       run;
        logic       buf_en;
        logic       xfer_top;
        logic       lvl_mode;
        logic       full_duty;
        logic       inv;
        logic       init_lvl;
        logic [1:0] pin_en;
    } ch_cfg_t;
endpackage

// File: rtl/cmp_store.sv
// Compare value store: optional holding register in front of the live
// compare register.
// Assumes: only one of direct write and transfer can act in a cycle
// (selected by buf_en).
module cmp_store #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         buf_en,
    input  logic         xfer_top,
    input  logic         tmr_zero,
    input  logic         tmr_top,
    output logic [W-1:0] creg
);
    logic [W-1:0] hold_q;
    logic         xfer_now;

    // Pick the transfer event requested for this channel
    always_comb xfer_now = buf_en && (xfer_top ? tmr_top : tmr_zero);

    // Holding register and live compare register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            creg   <= '0;
        end else begin
            if (wr && buf_en)  hold_q <= wdata;
            if (wr && !buf_en) creg   <= wdata;
            else if (xfer_now) creg   <= hold_q;
        end
    end
endmodule

// File: rtl/cmp_stop.sv
// Stop latch: halts a channel when its pin field arms the external stop.
// Assumes: a halt is released only by taking the channel out of run.
module cmp_stop (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] pin_en,
    input  logic       ext_stop,
    output logic       stop_now,
    output logic       halt,
    output logic       drv
);
    import cmp_pkg::*;

    // Stop request seen in this cycle
    always_comb stop_now = (pin_en == PIN_EN_STOPPABLE) && ext_stop;

    // Pin drive is valid for any non-zero pin field
    always_comb drv = (pin_en != 2'b00);

    // Sticky halt, cleared when the channel leaves run
    always_ff @(posedge clk) begin
        if (!rst_n)    halt <= 1'b0;
        else if (!run) halt <= 1'b0;
        else           halt <= halt | stop_now;
    end
endmodule

// File: rtl/cmp_drive.sv
// Output level engine for one channel: toggle or direction-level on a
// match, full-duty-range handling at zero and at or above the top.
// Assumes: ev already contains every match that may move this output;
// hit_own is the channel's own match, used for period tracking.
module cmp_drive #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         active,
    input  logic         lvl_mode,
    input  logic         force_toggle,
    input  logic         fd_on,
    input  logic         inv,
    input  logic         init_lvl,
    input  logic [W-1:0] creg,
    input  logic [W-1:0] top_val,
    input  logic         tmr_dn,
    input  logic         tmr_top,
    input  logic         ev,
    input  logic         hit_own,
    output logic         out
);
    logic seen_q;
    logic fd_zero;
    logic fd_high;
    logic seen_any;

    // Classify the compare value for full-duty handling
    always_comb begin
        fd_zero  = fd_on && (creg == '0);
        fd_high  = fd_on && !fd_zero && (creg >= top_val);
        seen_any = seen_q | hit_own;
    end

    // Output level and per-period match memory
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out    <= 1'b0;
            seen_q <= 1'b0;
        end else if (!run) begin
            out    <= init_lvl;
            seen_q <= 1'b0;
        end else if (active) begin
            seen_q <= tmr_top ? 1'b0 : seen_any;
            if (fd_zero) begin
                out <= inv;
            end else if (fd_high) begin
                if (tmr_top && !seen_any) out <= ~inv;
            end else if (ev) begin
                out <= (lvl_mode && !force_toggle) ? ~tmr_dn : ~out;
            end
        end
    end
endmodule

// File: rtl/cmp_out_pair.sv
// Two-channel output compare driven by an external timer.
// Assumes: tmr_zero and tmr_top are single-cycle pulses aligned with
// tmr_cnt; tmr_top_val is the timer's current top value.
module cmp_out_pair #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] tmr_cnt,
    input  logic [W-1:0] tmr_top_val,
    input  logic         tmr_dn,
    input  logic         tmr_zero,
    input  logic         tmr_top,
    input  logic [1:0]   buf_wr,
    input  logic [W-1:0] buf_wdata,
    input  logic [1:0]   ch_run,
    input  logic [1:0]   buf_en,
    input  logic [1:0]   xfer_top,
    input  logic [1:0]   lvl_mode,
    input  logic [1:0]   full_duty,
    input  logic [1:0]   inv_lvl,
    input  logic [1:0]   init_lvl,
    input  logic [1:0]   irq_en,
    input  logic [1:0]   flag_clr,
    input  logic [1:0]   pin_en0,
    input  logic [1:0]   pin_en1,
    input  logic         pair_pwm,
    input  logic         ext_stop,
    output logic [W-1:0] cmp_val0,
    output logic [W-1:0] cmp_val1,
    output logic [1:0]   pin_out,
    output logic [1:0]   pin_drv,
    output logic [1:0]   match_flag,
    output logic [1:0]   irq
);
    import cmp_pkg::*;

    ch_cfg_t          cfg    [NUM_CH];
    logic [W-1:0]     creg   [NUM_CH];
    logic [NUM_CH-1:0] halt_q;
    logic [NUM_CH-1:0] stop_now;
    logic [NUM_CH-1:0] active;
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] ev;
    logic              pair_hit;

    // Gather per-channel controls into one record each
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            cfg[c].run       = ch_run[c];
            cfg[c].buf_en    = buf_en[c];
            cfg[c].xfer_top  = xfer_top[c];
            cfg[c].lvl_mode  = lvl_mode[c];
            cfg[c].full_duty = full_duty[c];
            cfg[c].inv       = inv_lvl[c];
            cfg[c].init_lvl  = init_lvl[c];
        end
        cfg[0].pin_en = pin_en0;
        cfg[1].pin_en = pin_en1;
    end

    // Match detection and channel-1 pairing with channel 0's value
    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            active[c] = cfg[c].run && !halt_q[c] && !stop_now[c];
            hit[c]    = active[c] && (tmr_cnt == creg[c]);
        end
        pair_hit = pair_pwm && active[1] && (tmr_cnt == creg[0]);
        ev[0]    = hit[0];
        ev[1]    = hit[1] | pair_hit;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        cmp_store #(.W(W)) u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (buf_wr[g]),
            .wdata    (buf_wdata),
            .buf_en   (cfg[g].buf_en),
            .xfer_top (cfg[g].xfer_top),
            .tmr_zero (tmr_zero),
            .tmr_top  (tmr_top),
            .creg     (creg[g])
        );

        cmp_stop u_stop (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (cfg[g].run),
            .pin_en   (cfg[g].pin_en),
            .ext_stop (ext_stop),
            .stop_now (stop_now[g]),
            .halt     (halt_q[g]),
            .drv      (pin_drv[g])
        );

        cmp_drive #(.W(W)) u_drive (
            .clk          (clk),
            .rst_n        (rst_n),
            .run          (cfg[g].run),
            .active       (active[g]),
            .lvl_mode     (cfg[g].lvl_mode),
            .force_toggle ((g == 1) && pair_pwm),
            .fd_on        (cfg[g].full_duty && !pair_pwm),
            .inv          (cfg[g].inv),
            .init_lvl     (cfg[g].init_lvl),
            .creg         (creg[g]),
            .top_val      (tmr_top_val),
            .tmr_dn       (tmr_dn),
            .tmr_top      (tmr_top),
            .ev           (ev[g]),
            .hit_own      (hit[g]),
            .out          (pin_out[g])
        );

        // Match flag: set on own match, cleared by strobe, set wins
        always_ff @(posedge clk) begin
            if (!rst_n)           match_flag[g] <= 1'b0;
            else if (hit[g])      match_flag[g] <= 1'b1;
            else if (flag_clr[g]) match_flag[g] <= 1'b0;
        end

        // Interrupt request gated by its enable
        always_comb irq[g] = match_flag[g] & irq_en[g];
    end

    assign cmp_val0 = creg[0];
    assign cmp_val1 = creg[1];
endmodule

// File: rtl/cmp_out_pair_chk.sv
// Property checker for cmp_out_pair, attached by bind below.
// Assumes: halt is the top's internal sticky halt vector.
module cmp_out_pair_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] tmr_cnt,
    input logic         tmr_zero,
    input logic         tmr_top,
    input logic [1:0]   buf_en,
    input logic [1:0]   ch_run,
    input logic [1:0]   init_lvl,
    input logic [1:0]   full_duty,
    input logic [1:0]   inv_lvl,
    input logic [1:0]   irq_en,
    input logic [1:0]   pin_en0,
    input logic         pair_pwm,
    input logic         ext_stop,
    input logic [W-1:0] cmp_val0,
    input logic [1:0]   pin_out,
    input logic [1:0]   pin_drv,
    input logic [1:0]   match_flag,
    input logic [1:0]   irq,
    input logic [1:0]   halt
);
    // R3: buffered value stays put between transfer events
    p_hidden_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_en[0] && !tmr_zero && !tmr_top) |=> $stable(cmp_val0));

    // R6: idle channel follows its initial level
    p_init_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_run[0] |=> (pin_out[0] == $past(init_lvl[0])));

    // R7: a flag only rises after a running channel saw its value
    p_flag_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_flag[0]) |-> $past(ch_run[0] && (tmr_cnt == cmp_val0)));

    // R7: interrupt needs flag and enable
    p_irq_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq[1] |-> (match_flag[1] && irq_en[1]));

    // R9: zero compare value in full-duty mode pins the output
    p_zero_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_run[0] && full_duty[0] && !pair_pwm && (cmp_val0 == '0) &&
         !halt[0] && !((pin_en0 == 2'b11) && ext_stop))
        |=> (pin_out[0] == $past(inv_lvl[0])));

    // R11: a halted running channel holds its level
    p_halt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (halt[0] && ch_run[0]) |=> $stable(pin_out[0]));

    // R12: released pin field drops drive
    p_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_en0 == 2'b00) |-> !pin_drv[0]);
endmodule

bind cmp_out_pair cmp_out_pair_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tmr_cnt    (tmr_cnt),
    .tmr_zero   (tmr_zero),
    .tmr_top    (tmr_top),
    .buf_en     (buf_en),
    .ch_run     (ch_run),
    .init_lvl   (init_lvl),
    .full_duty  (full_duty),
    .inv_lvl    (inv_lvl),
    .irq_en     (irq_en),
    .pin_en0    (pin_en0),
    .pair_pwm   (pair_pwm),
    .ext_stop   (ext_stop),
    .cmp_val0   (cmp_val0),
    .pin_out    (pin_out),
    .pin_drv    (pin_drv),
    .match_flag (match_flag),
    .irq        (irq),
    .halt       (halt_q)
);

// File: tb/cmp_out_pair_tb.sv
// Bench: behavioural reference model compared on every clock.
module cmp_out_pair_tb;
    localparam int W   = 8;
    localparam int TOP = 9;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] tmr_cnt;
    logic [W-1:0] tmr_top_val;
    logic         tmr_dn;
    logic         tmr_zero, tmr_top;
    logic [1:0]   buf_wr, ch_run, buf_en, xfer_top, lvl_mode, full_duty;
    logic [1:0]   inv_lvl, init_lvl, irq_en, flag_clr, pin_en0, pin_en1;
    logic [W-1:0] buf_wdata;
    logic         pair_pwm, ext_stop;
    logic [W-1:0] cmp_val0, cmp_val1;
    logic [1:0]   pin_out, pin_drv, match_flag, irq;

    int    n_checks = 0;
    int    n_fail   = 0;
    string phase    = "R1";

    // Timer stimulus
    logic  t_go = 1'b0;
    logic  t_updown = 1'b0;
    logic  t_clr = 1'b0;
    int    t_cnt = 0;
    logic  t_dir = 1'b0;

    // Reference model state
    int   m_creg [2];
    int   m_hold [2];
    logic m_out  [2];
    logic m_seen [2];
    logic m_halt [2];
    logic m_flag [2];

    cmp_out_pair #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .tmr_top_val(tmr_top_val),
        .tmr_dn(tmr_dn), .tmr_zero(tmr_zero), .tmr_top(tmr_top),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata), .ch_run(ch_run), .buf_en(buf_en),
        .xfer_top(xfer_top), .lvl_mode(lvl_mode), .full_duty(full_duty),
        .inv_lvl(inv_lvl), .init_lvl(init_lvl), .irq_en(irq_en),
        .flag_clr(flag_clr), .pin_en0(pin_en0), .pin_en1(pin_en1),
        .pair_pwm(pair_pwm), .ext_stop(ext_stop), .cmp_val0(cmp_val0),
        .cmp_val1(cmp_val1), .pin_out(pin_out), .pin_drv(pin_drv),
        .match_flag(match_flag), .irq(irq)
    );

    always #5 clk = ~clk;

    assign tmr_cnt     = W'(t_cnt);
    assign tmr_top_val = W'(TOP);
    assign tmr_dn      = t_dir;
    assign tmr_zero    = t_go && (t_cnt == 0);
    assign tmr_top     = t_go && (t_cnt == TOP);

    // Timer: up-count wrapping at TOP, or up/down between 0 and TOP
    always @(negedge clk) begin
        if (t_clr) begin
            t_cnt = 0; t_dir = 1'b0;
        end else if (t_go) begin
            if (!t_updown) begin
                t_dir = 1'b0;
                t_cnt = (t_cnt == TOP) ? 0 : t_cnt + 1;
            end else if (!t_dir) begin
                if (t_cnt == TOP) begin t_dir = 1'b1; t_cnt = TOP - 1; end
                else t_cnt = t_cnt + 1;
            end else begin
                if (t_cnt == 0) begin t_dir = 1'b0; t_cnt = 1; end
                else t_cnt = t_cnt - 1;
            end
        end
    end

    // Reference model, advanced on each rising edge
    always @(posedge clk) begin
        logic act [2];
        logic hit [2];
        logic ev  [2];
        logic [1:0] pe;
        int   old_creg0;
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_creg[c] = 0; m_hold[c] = 0; m_out[c] = 0;
                m_seen[c] = 0; m_halt[c] = 0; m_flag[c] = 0;
            end
        end else begin
            old_creg0 = m_creg[0];
            for (int c = 0; c < 2; c++) begin
                pe = (c == 0) ? pin_en0 : pin_en1;
                act[c] = ch_run[c] && !m_halt[c] && !(pe == 2'b11 && ext_stop);
                hit[c] = act[c] && (int'(tmr_cnt) == m_creg[c]);
            end
            ev[0] = hit[0];
            ev[1] = hit[1] || (pair_pwm && act[1] && int'(tmr_cnt) == old_creg0);
            for (int c = 0; c < 2; c++) begin
                logic fd;
                logic any;
                pe = (c == 0) ? pin_en0 : pin_en1;
                fd  = full_duty[c] && !pair_pwm;
                any = m_seen[c] || hit[c];
                if (!ch_run[c]) begin
                    m_out[c] = init_lvl[c]; m_seen[c] = 0;
                end else if (act[c]) begin
                    if (fd && m_creg[c] == 0) m_out[c] = inv_lvl[c];
                    else if (fd && m_creg[c] >= TOP) begin
                        if (tmr_top && !any) m_out[c] = !inv_lvl[c];
                    end else if (ev[c]) begin
                        if (lvl_mode[c] && !(c == 1 && pair_pwm)) m_out[c] = !tmr_dn;
                        else m_out[c] = !m_out[c];
                    end
                    m_seen[c] = tmr_top ? 1'b0 : any;
                end
                if (hit[c]) m_flag[c] = 1;
                else if (flag_clr[c]) m_flag[c] = 0;
                if (!ch_run[c]) m_halt[c] = 0;
                else if (pe == 2'b11 && ext_stop) m_halt[c] = 1;
                if (buf_wr[c]) begin
                    if (buf_en[c]) begin
                        if (xfer_top[c] ? tmr_top : tmr_zero) m_creg[c] = m_hold[c];
                        m_hold[c] = int'(buf_wdata);
                    end else m_creg[c] = int'(buf_wdata);
                end else if (buf_en[c] && (xfer_top[c] ? tmr_top : tmr_zero))
                    m_creg[c] = m_hold[c];
            end
        end
    end

    task automatic chk(string what, int got, int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s got %0d expected %0d at %0t", phase, what, got, exp, $time);
        end
    endtask

    // Advance one clock and compare all outputs at the falling edge
    task automatic cyc(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("cmp_val0", int'(cmp_val0), m_creg[0]);
            chk("cmp_val1", int'(cmp_val1), m_creg[1]);
            for (int c = 0; c < 2; c++) begin
                logic [1:0] pe;
                pe = (c == 0) ? pin_en0 : pin_en1;
                chk($sformatf("pin_out[%0d]", c), int'(pin_out[c]), int'(m_out[c]));
                chk($sformatf("match_flag[%0d]", c), int'(match_flag[c]), int'(m_flag[c]));
                chk($sformatf("irq[%0d]", c), int'(irq[c]), int'(m_flag[c] && irq_en[c]));
                chk($sformatf("pin_drv[%0d]", c), int'(pin_drv[c]), int'(pe != 2'b00));
            end
        end
    endtask

    task automatic wr(int c, int v);
        buf_wr[c] = 1'b1; buf_wdata = W'(v);
        cyc();
        buf_wr = '0;
    endtask

    task automatic restart_timer(logic ud);
        t_clr = 1'b1; cyc(); t_clr = 1'b0;
        t_updown = ud; t_go = 1'b1;
    endtask

    // Watchdog
    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired in phase %s", phase);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; buf_wr = '0; buf_wdata = '0; ch_run = '0; buf_en = '0;
        xfer_top = '0; lvl_mode = '0; full_duty = '0; inv_lvl = '0;
        init_lvl = '0; irq_en = '0; flag_clr = '0; pin_en0 = '0; pin_en1 = '0;
        pair_pwm = 1'b0; ext_stop = 1'b0;
        phase = "R1"; cyc(3);
        chk("R1 reset pin_out", int'(pin_out), 0);
        chk("R1 reset cmp_val0", int'(cmp_val0), 0);
        rst_n = 1'b1;

        phase = "R2"; wr(0, 5); wr(1, 7); cyc(2);
        chk("R2 direct cmp_val0", int'(cmp_val0), 5);

        phase = "R6"; init_lvl = 2'b01; cyc(3);
        chk("R6 idle level", int'(pin_out), 1);
        init_lvl = 2'b10; restart_timer(1'b0); cyc(12);

        phase = "R4"; ch_run = 2'b11; pin_en0 = 2'b01; pin_en1 = 2'b10;
        irq_en = 2'b11; cyc(40);
        phase = "R7"; flag_clr = 2'b11; cyc(6); flag_clr = 2'b01; cyc(15); flag_clr = '0;
        irq_en = 2'b10; cyc(10);

        phase = "R5"; lvl_mode = 2'b11; restart_timer(1'b1); cyc(60);
        lvl_mode = '0;

        phase = "R3"; buf_en = 2'b11; xfer_top = 2'b10; restart_timer(1'b0);
        cyc(3); wr(0, 2); wr(1, 8); cyc(25); wr(0, 6); cyc(4); wr(1, 3); cyc(30);
        buf_en = '0;

        phase = "R8"; pair_pwm = 1'b1; lvl_mode = 2'b10; wr(0, 3); wr(1, 7); cyc(40);
        wr(0, 5); wr(1, 5); cyc(30);
        phase = "R10"; full_duty = 2'b11; cyc(20);   // pairing overrides full duty
        pair_pwm = 1'b0; lvl_mode = '0;

        phase = "R9"; inv_lvl = 2'b01; wr(0, 0); wr(1, 4); cyc(30);
        inv_lvl = 2'b10; cyc(20);

        phase = "R10"; inv_lvl = 2'b00; wr(0, TOP); wr(1, 12); cyc(40);
        inv_lvl = 2'b11; cyc(30); restart_timer(1'b1); cyc(40);
        full_duty = '0;

        phase = "R11"; wr(0, 4); wr(1, 6); restart_timer(1'b0); cyc(7);
        pin_en0 = 2'b11; ext_stop = 1'b1; cyc(2); ext_stop = 1'b0; cyc(25);
        ch_run = 2'b10; cyc(2); ch_run = 2'b11; cyc(20);
        pin_en1 = 2'b11; ext_stop = 1'b1; cyc(5); ext_stop = 1'b0; cyc(15);

        phase = "R12"; pin_en0 = 2'b00; pin_en1 = 2'b00; cyc(3);
        chk("R12 released drive", int'(pin_drv), 0);
        pin_en1 = 2'b01; cyc(3);

        phase = "R1"; rst_n = 1'b0; cyc(2);
        chk("R1 second reset flags", int'(match_flag), 0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule